// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Buffered Status Flags

This block takes an asynchronous serial line and rebuilds characters from it. A prescaler divides the system clock into sampling ticks. Each bit lasts 16 ticks, or 8 ticks when double speed is selected. Three samples are taken at the centre of every bit, and a two-of-three vote decides the bit value. Each finished character is stored with its own framing and parity results. It goes into a two-slot queue, and a third character may wait behind the queue in a holding register. The host pops the queue head with a single-cycle read strobe.

The receiver offers an optional address filter for multi-drop links. When it is on, each frame carries an extra indicator bit, and frames that do not mark an address are thrown away. The block also keeps a transmit-buffer-empty status for the host. It is set after reset, cleared when the host loads the transmit buffer, and set again when the transmitter takes the data.

Top module: `serial_rx_unit`

## Requirements
- R1: `tx_empty` is 1 after reset. A `tx_wr` pulse clears it on the next cycle. A `tx_take` pulse without `tx_wr` sets it on the next cycle.
- R2: A frame is a low start bit, then `DATA_BITS` data bits with the least significant bit first, then the address indicator if `mp_en` is set, then the parity bit if `par_en` is set, then the stop bit. With `dbl_speed` low, one bit lasts 16 × (`presc`+1) clock cycles.
- R3: With `dbl_speed` high, one bit lasts 8 × (`presc`+1) clock cycles, and data is recovered correctly at that rate.
- R4: A bit value is the majority of three samples taken on consecutive ticks at the bit centre. A disturbance on the line that lasts one tick does not change the received data.
- R5: If the start bit votes high at its centre, it is a glitch. No character is stored and the receiver goes back to idle.
- R6: `rx_fe` for a character is 1 exactly when its first stop bit voted 0.
- R7: The parity bit covers the data bits only. Even parity is `par_odd`=0 and odd parity is `par_odd`=1. `rx_pe` is 1 only if the parity check failed and `par_en` was set when the frame started. Changing `par_en` or `par_odd` after a frame has started does not change the flag stored for it.
- R8: `rx_data`, `rx_fe` and `rx_pe` show the queue head and stay stable until a read. A read pops the head, moves the next slot up, and moves a waiting held character into the freed slot.
- R9: `rx_irq` is 1 whenever the queue holds at least one character.
- R10: `rx_ovr` is set only when a valid start bit is detected while both queue slots are full and a character is waiting in the holding register. It is cleared by the next read. The character that arrives in that state is discarded.
- R11: While `mp_en` is set, a frame whose address indicator is 0 is discarded: nothing is stored and no flag changes. A frame whose indicator is 1 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| presc | input | PRESC_W | Tick period minus one, in clock cycles |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit instead of 16 |
| par_en | input | 1 | Enables the parity bit and the parity check |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| mp_en | input | 1 | Enables the address indicator bit and the address filter |
| rd_strobe | input | 1 | Host read; pops the queue head |
| tx_wr | input | 1 | Host loaded the transmit buffer |
| tx_take | input | 1 | Transmitter took the transmit buffer data |
| rx_data | output | DATA_BITS | Data of the queue head |
| rx_fe | output | 1 | Framing error of the queue head |
| rx_pe | output | 1 | Parity error of the queue head |
| rx_ovr | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt: queue not empty |
| tx_empty | output | 1 | Transmit buffer empty |

## Verification
A table of frames drives the main receive path. The rows mix both bit rates, parity off, even and odd parity with correct and with wrong parity bits, and good and bad stop bits, so that each flag is tested on its own and in combination. Data values run from all zeros and all ones to alternating patterns, which exposes errors in bit order and bit timing. Directed tests then cover a short false start, a one-tick glitch inside a data bit, a parity flag that must survive a later change of the enable, the address filter, and a burst of four frames without reads. The burst separates a full queue, which must not raise overrun, from a full queue with a held character plus a new start, which must.

// File: rtl/serial_rx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: no other block depends on the encodings below.
package serial_rx_pkg;

    // Receive state machine: one state for each field of a frame.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PAR,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/rx_tick_gen.sv
// Module: rx_tick_gen
// Divides the system clock into sampling ticks. One tick lasts presc+1
// clock cycles. restart realigns the divider to the cycle after a start
// edge is detected.
// Assumes: presc stays constant while a frame is being received.
module rx_tick_gen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);

    logic [PRESC_W-1:0] div_q;

    // Prescale counter: wraps at presc and is cleared when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || (div_q == presc)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = !restart && (div_q == presc);

endmodule

// File: rtl/rx_frame_engine.sv
// Module: rx_frame_engine
// Recovers bits from the oversampled line, then checks framing, parity and
// the address indicator. Emits a one-cycle done pulse for each accepted
// frame. The mode inputs are latched when the start edge is seen.
// Assumes: OS_FULL is a power of two of at least 8; rxd may be asynchronous.
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OS_FULL   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 tick,
    input  logic                 dbl_speed,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 mp_en,
    output logic                 restart,
    output logic                 start_seen,
    output logic                 done,
    output logic [DATA_BITS-1:0] done_data,
    output logic                 done_fe,
    output logic                 done_pe
);

    localparam int PHW = $clog2(OS_FULL);
    localparam int IW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [PHW-1:0] MID_F  = PHW'(OS_FULL / 2);
    localparam logic [PHW-1:0] MID_H  = PHW'(OS_FULL / 4);
    localparam logic [PHW-1:0] LAST_F = PHW'(OS_FULL - 1);
    localparam logic [PHW-1:0] LAST_H = PHW'(OS_FULL / 2 - 1);
    localparam logic [IW-1:0]  LAST_I = IW'(DATA_BITS - 1);

    logic [1:0]           sync_q;
    logic                 prev_q;
    logic                 rx_s;
    rx_state_e            state_q;
    logic [PHW-1:0]       ph_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 addr_q, pbit_q, s_a_q, s_b_q;
    logic                 dbl_l, par_l, odd_l, mp_l;
    logic [PHW-1:0]       mid_ph, last_ph;
    logic                 decide, maj;
    rx_state_e            after_data;

    assign rx_s = sync_q[1];

    // Two-stage synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], rxd};
            prev_q <= sync_q[1];
        end
    end

    assign mid_ph  = dbl_l ? MID_H : MID_F;
    assign last_ph = dbl_l ? LAST_H : LAST_F;
    assign restart = (state_q == ST_IDLE) && prev_q && !rx_s;
    assign decide  = tick && (state_q != ST_IDLE) && (ph_q == mid_ph + 1'b1);
    assign maj     = (s_a_q & s_b_q) | (s_a_q & rx_s) | (s_b_q & rx_s);

    assign after_data = mp_l ? ST_ADDR : (par_l ? ST_PAR : ST_STOP);

    // Bit timing, sampling and field sequencing for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            addr_q  <= 1'b0;
            pbit_q  <= 1'b0;
            s_a_q   <= 1'b1;
            s_b_q   <= 1'b1;
            dbl_l   <= 1'b0;
            par_l   <= 1'b0;
            odd_l   <= 1'b0;
            mp_l    <= 1'b0;
        end else if (restart) begin
            state_q <= ST_START;
            ph_q    <= '0;
            idx_q   <= '0;
            dbl_l   <= dbl_speed;
            par_l   <= par_en;
            odd_l   <= par_odd;
            mp_l    <= mp_en;
        end else if (tick && (state_q != ST_IDLE)) begin
            if (ph_q == mid_ph - 1'b1) s_a_q <= rx_s;
            if (ph_q == mid_ph)        s_b_q <= rx_s;
            if (decide) begin
                unique case (state_q)
                    ST_DATA: shreg_q <= {maj, shreg_q[DATA_BITS-1:1]};
                    ST_ADDR: addr_q  <= maj;
                    ST_PAR:  pbit_q  <= maj;
                    default: ;
                endcase
            end
            if (decide && (state_q == ST_START) && maj) begin
                state_q <= ST_IDLE;
            end else if (decide && (state_q == ST_STOP)) begin
                state_q <= ST_IDLE;
            end else if (ph_q == last_ph) begin
                ph_q <= '0;
                unique case (state_q)
                    ST_START: state_q <= ST_DATA;
                    ST_DATA: begin
                        if (idx_q == LAST_I) state_q <= after_data;
                        idx_q <= idx_q + 1'b1;
                    end
                    ST_ADDR: state_q <= par_l ? ST_PAR : ST_STOP;
                    ST_PAR:  state_q <= ST_STOP;
                    default: ;
                endcase
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign start_seen = decide && (state_q == ST_START) && !maj;
    assign done       = decide && (state_q == ST_STOP) && (!mp_l || addr_q);
    assign done_data  = shreg_q;
    assign done_fe    = !maj;
    assign done_pe    = par_l && (((^shreg_q) ^ pbit_q) != odd_l);

endmodule

// File: rtl/rx_char_queue.sv
// Module: rx_char_queue
// Queue of DEPTH received characters, each stored with its own error flags,
// plus one holding slot for a character waiting behind a full queue. Keeps
// the overrun flag, which is raised by a start edge while everything is full.
// Assumes: push and start_seen are single-cycle pulses.
module rx_char_queue #(
    parameter int EW    = 10,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [EW-1:0]                push_entry,
    input  logic                         pop,
    input  logic                         start_seen,
    output logic [EW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         hold_full,
    output logic                         ovr
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [EW-1:0] slot_q [DEPTH];
    logic [EW-1:0] slot_n [DEPTH];
    logic [EW-1:0] hold_q, hold_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          hv_q, hv_n, ovr_q, ovr_n;
    logic          do_pop;

    assign do_pop = pop && (cnt_q != '0);

    // Next state: pop first, then push, then the overrun condition.
    always_comb begin
        slot_n = slot_q;
        hold_n = hold_q;
        cnt_n  = cnt_q;
        hv_n   = hv_q;
        ovr_n  = ovr_q;
        if (do_pop) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot_q[i+1];
            if (hv_q) begin
                slot_n[DEPTH-1] = hold_q;
                hv_n            = 1'b0;
            end else begin
                cnt_n = cnt_q - 1'b1;
            end
            ovr_n = 1'b0;
        end
        if (push) begin
            if (cnt_n < FULL) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == cnt_n) slot_n[i] = push_entry;
                end
                cnt_n = cnt_n + 1'b1;
            end else if (!hv_n) begin
                hold_n = push_entry;
                hv_n   = 1'b1;
            end
        end
        if (start_seen && (cnt_q == FULL) && hv_q && !do_pop) ovr_n = 1'b1;
    end

    // State registers of the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            hold_q <= '0;
            cnt_q  <= '0;
            hv_q   <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            slot_q <= slot_n;
            hold_q <= hold_n;
            cnt_q  <= cnt_n;
            hv_q   <= hv_n;
            ovr_q  <= ovr_n;
        end
    end

    assign head      = slot_q[0];
    assign count     = cnt_q;
    assign hold_full = hv_q;
    assign ovr       = ovr_q;

endmodule

// File: rtl/serial_rx_unit.sv
// Module: serial_rx_unit (top)
// Asynchronous serial receiver with a queue of characters, per-character
// error flags, overrun detection, an address filter and a transmit-empty
// status. Connects the tick divider, the frame engine and the queue.
// Assumes: all host strobes are synchronous to clk.
module serial_rx_unit #(
    parameter int DATA_BITS = 8,
    parameter int PRESC_W   = 8,
    parameter int OS_FULL   = 16,
    parameter int DEPTH     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic [PRESC_W-1:0]   presc,
    input  logic                 dbl_speed,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 mp_en,
    input  logic                 rd_strobe,
    input  logic                 tx_wr,
    input  logic                 tx_take,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_fe,
    output logic                 rx_pe,
    output logic                 rx_ovr,
    output logic                 rx_irq,
    output logic                 tx_empty
);

    localparam int EW = DATA_BITS + 2;
    localparam int CW = $clog2(DEPTH + 1);

    logic                 tick, restart, start_seen, push_v;
    logic [DATA_BITS-1:0] f_data;
    logic                 f_fe, f_pe;
    logic [EW-1:0]        head;
    logic [CW-1:0]        q_count;
    logic                 hold_full;
    logic                 txe_q;

    rx_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .presc(presc), .tick(tick)
    );

    rx_frame_engine #(.DATA_BITS(DATA_BITS), .OS_FULL(OS_FULL)) u_eng (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick),
        .dbl_speed(dbl_speed), .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en),
        .restart(restart), .start_seen(start_seen), .done(push_v),
        .done_data(f_data), .done_fe(f_fe), .done_pe(f_pe)
    );

    rx_char_queue #(.EW(EW), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(push_v), .push_entry({f_data, f_fe, f_pe}),
        .pop(rd_strobe), .start_seen(start_seen), .head(head),
        .count(q_count), .hold_full(hold_full), .ovr(rx_ovr)
    );

    // Transmit-empty status: set by reset and by a take, cleared by a host load.
    always_ff @(posedge clk) begin
        if (!rst_n)       txe_q <= 1'b1;
        else if (tx_wr)   txe_q <= 1'b0;
        else if (tx_take) txe_q <= 1'b1;
    end

    assign tx_empty = txe_q;
    assign rx_data  = head[EW-1:2];
    assign rx_fe    = head[1];
    assign rx_pe    = head[0];
    assign rx_irq   = (q_count != '0);

endmodule

// File: rtl/serial_rx_chk.sv
// Module: serial_rx_chk
// Protocol checker bound to serial_rx_unit. It watches the ports and a few
// internal nets that connect the sub-blocks.
// Assumes: same clock and reset as the unit.
module serial_rx_chk #(
    parameter int DATA_BITS = 8,
    parameter int CW        = 2,
    parameter int DEPTH     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_wr,
    input logic                 tx_take,
    input logic                 tx_empty,
    input logic                 rd_strobe,
    input logic                 rx_irq,
    input logic                 rx_ovr,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_fe,
    input logic                 rx_pe,
    input logic [CW-1:0]        q_count,
    input logic                 hold_full,
    input logic                 push_v
);

    // R1
    txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    // R1
    txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !tx_wr) |=> tx_empty);

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rd_strobe) |=> ($stable(rx_data) && $stable(rx_fe) && $stable(rx_pe)));

    // R9
    irq_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (q_count == CW'(1)) && !hold_full && !push_v) |=> !rx_irq);

    // R10
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> ($past(q_count) == CW'(DEPTH) && $past(hold_full)));

    // R10
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rx_irq) |=> !rx_ovr);

endmodule

bind serial_rx_unit serial_rx_chk #(
    .DATA_BITS(DATA_BITS), .CW($clog2(DEPTH + 1)), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_take(tx_take), .tx_empty(tx_empty),
    .rd_strobe(rd_strobe), .rx_irq(rx_irq), .rx_ovr(rx_ovr), .rx_data(rx_data),
    .rx_fe(rx_fe), .rx_pe(rx_pe), .q_count(q_count), .hold_full(hold_full),
    .push_v(push_v)
);

// File: tb/serial_rx_unit_tb.sv
// Bench for serial_rx_unit: a table of frames walked by one loop, then
// directed tests for reset, glitches, flag lifetime, filter and overrun.
module serial_rx_unit_tb;

    localparam int PRESC = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] presc = 8'(PRESC);
    logic       dbl_speed = 1'b0, par_en = 1'b0, par_odd = 1'b0, mp_en = 1'b0;
    logic       rd_strobe = 1'b0, tx_wr = 1'b0, tx_take = 1'b0;
    logic [7:0] rx_data;
    logic       rx_fe, rx_pe, rx_ovr, rx_irq, tx_empty;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serial_rx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .presc(presc), .dbl_speed(dbl_speed),
        .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en), .rd_strobe(rd_strobe),
        .tx_wr(tx_wr), .tx_take(tx_take), .rx_data(rx_data), .rx_fe(rx_fe),
        .rx_pe(rx_pe), .rx_ovr(rx_ovr), .rx_irq(rx_irq), .tx_empty(tx_empty)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       dbl;
        logic       pen;
        logic       podd;
        logic       badp;
        logic       stop;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{8'h7E, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic line(logic v, int n);
        rxd = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Sends one frame; glitch_bit >= 0 puts a 2-cycle pulse mid data bit.
    task automatic send(logic [7:0] d, logic dbl, logic pen, logic podd, logic badp,
                        logic use_addr, logic addr, logic stop, int glitch_bit);
        int bclk;
        logic p;
        dbl_speed = dbl; par_en = pen; par_odd = podd; mp_en = use_addr;
        bclk = (PRESC + 1) * (dbl ? 8 : 16);
        p = (^d) ^ podd ^ badp;
        line(1'b0, bclk);
        for (int i = 0; i < 8; i++) begin
            if (i == glitch_bit) begin
                line(d[i], bclk / 2);
                line(~d[i], 2);
                line(d[i], bclk / 2 - 2);
            end else begin
                line(d[i], bclk);
            end
        end
        if (use_addr) line(addr, bclk);
        if (pen) line(p, bclk);
        line(stop, bclk);
        line(1'b1, bclk + 4);
        @(negedge clk);
    endtask

    task automatic host_read;
        @(posedge clk); #1;
        rd_strobe = 1'b1;
        @(posedge clk); #1;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_empty after reset", tx_empty, 1);
        check("R9 irq after reset", rx_irq, 0);
        check("R10 ovr after reset", rx_ovr, 0);

        // R1 load and take
        @(posedge clk); #1 tx_wr = 1'b1;
        @(posedge clk); #1 tx_wr = 1'b0;
        @(negedge clk);
        check("R1 tx_empty cleared by load", tx_empty, 0);
        @(posedge clk); #1 tx_take = 1'b1;
        @(posedge clk); #1 tx_take = 1'b0;
        @(negedge clk);
        check("R1 tx_empty set by take", tx_empty, 1);

        // R2 R3 R6 R7 table of frames
        foreach (VECS[k]) begin
            send(VECS[k].d, VECS[k].dbl, VECS[k].pen, VECS[k].podd, VECS[k].badp,
                 1'b0, 1'b0, VECS[k].stop, -1);
            check("R9 irq with character", rx_irq, 1);
            check(VECS[k].dbl ? "R3 data at 8x" : "R2 data at 16x", rx_data, VECS[k].d);
            check("R6 framing flag", rx_fe, !VECS[k].stop);
            check("R7 parity flag", rx_pe, VECS[k].pen & VECS[k].badp);
            host_read();
            check("R9 irq after drain", rx_irq, 0);
        end

        // R5 false start: low far shorter than half a bit
        line(1'b0, 6);
        line(1'b1, 80);
        @(negedge clk);
        check("R5 false start ignored", rx_irq, 0);

        // R4 one-tick glitch inside a data bit at both rates
        send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2);
        check("R4 glitch at 16x", rx_data, 8'hC3);
        host_read();
        send(8'h96, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5);
        check("R4 glitch at 8x", rx_data, 8'h96);
        host_read();

        // R7 stored parity flag survives a later change of the enable
        send(8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, -1);
        par_en = 1'b0; par_odd = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 flag kept after enable change", rx_pe, 1);
        host_read();

        // R11 address filter
        send(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, -1);
        check("R11 data frame dropped", rx_irq, 0);
        check("R11 no flag from dropped frame", rx_ovr, 0);
        send(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, -1);
        check("R11 address frame kept", rx_data, 8'h5A);
        check("R11 address frame parity", rx_pe, 0);
        host_read();

        // R10 overrun sequence; R8 order of flags and characters
        send(8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, -1);
        send(8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        send(8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        check("R10 no overrun without new start", rx_ovr, 0);
        check("R8 head is first character", rx_data, 8'h01);
        check("R8 head parity flag", rx_pe, 1);
        send(8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        check("R10 overrun raised", rx_ovr, 1);
        check("R8 head unchanged by overrun", rx_data, 8'h01);
        host_read();
        check("R10 overrun cleared by read", rx_ovr, 0);
        check("R8 second character moves up", rx_data, 8'h02);
        check("R8 flags travel with character", {rx_fe, rx_pe}, 2'b10);
        host_read();
        check("R8 held character enters queue", rx_data, 8'h03);
        check("R8 held character flags", {rx_fe, rx_pe}, 2'b00);
        host_read();
        check("R10 overrun character discarded", rx_irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule